// File: doc/BRIEF.md
# RTS flow control generator

This block produces the ready-to-send level for a serial receiver. It watches how many bytes sit in the receive FIFO and tells the far end to pause once that number reaches a programmable limit. It can also hand control of the line to software, which then sets the level directly.

Configuration arrives as plain inputs: a function enable, a mode select, a threshold, an output-invert bit and a software level. The FIFO occupancy comes from the receive path. The output is a single registered level meant for the pad. A low level means "ready" and a high level means "stop" when the output is not inverted.

Top module: `rts_flow_ctrl`

## Requirements
- R1: While `rst_n` is low, `rts_o` is 0.
- R2: When `en` is 0 at a clock edge, `rts_o` is 0 after that edge, whatever the mode, invert bit, level, threshold and count are.
- R3: In automatic mode (`en`=1, `manual_mode`=0, `invert`=0), `rts_o` is 1 when `rx_count` >= `thresh` and 0 when `rx_count` < `thresh`.
- R4: In automatic mode with `invert`=1, `rts_o` is the complement of the R3 value: 0 when `rx_count` >= `thresh` and 1 otherwise.
- R5: In manual mode (`en`=1, `manual_mode`=1), `rts_o` equals `manual_level`, and `invert` has no effect on it.
- R6: In manual mode, `rx_count` and `thresh` have no effect on `rts_o`.
- R7: `rts_o` changes only on a rising clock edge. It reflects the inputs sampled at the most recent edge, so a change in `rx_count` that crosses the threshold shows up one edge later.
- R8: In automatic mode, `thresh`=0 gives the stop level for every count. `thresh` equal to the largest count value gives the ready level at every count below that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enables the flow-control function |
| manual_mode | input | 1 | Mode select: 0 automatic, 1 manual |
| thresh | input | CNT_W | FIFO level at or above which the stop level is driven |
| invert | input | 1 | Inverts the output in automatic mode only |
| manual_level | input | 1 | Output level used in manual mode |
| rx_count | input | CNT_W | Current receive FIFO occupancy |
| rts_o | output | 1 | Registered ready-to-send level |

## Verification
The hardest condition to reach from the ports is the exact threshold boundary. The output has to flip when the count goes from thresh-1 to thresh, and it has to do so in the right cycle. Random counts only land on that boundary now and then. The stimulus therefore walks the count up and down across the threshold one step at a time, with and without inversion. It also tests threshold 0 and the largest threshold value. On top of that, a long random run moves between modes, and the invert bit is toggled while manual mode is active.

// File: rtl/rts_flow_ctrl.sv
module rts_flow_ctrl #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             manual_mode,
  input  logic [CNT_W-1:0] thresh,
  input  logic             invert,
  input  logic             manual_level,
  input  logic [CNT_W-1:0] rx_count,
  output logic             rts_o
);

  localparam logic READY = 1'b0;

  logic fifo_full_enough;
  logic auto_level;
  logic rts_d;
  logic rts_q;

  assign fifo_full_enough = (rx_count >= thresh);
  assign auto_level       = fifo_full_enough ^ invert;

  always_comb begin
    if (!en)
      rts_d = READY;
    else if (manual_mode)
      rts_d = manual_level;
    else
      rts_d = auto_level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rts_q <= READY;
    else
      rts_q <= rts_d;
  end

  assign rts_o = rts_q;

endmodule

// File: rtl/rts_flow_ctrl_chk.sv
module rts_flow_ctrl_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             manual_mode,
  input logic [CNT_W-1:0] thresh,
  input logic             invert,
  input logic             manual_level,
  input logic [CNT_W-1:0] rx_count,
  input logic             rts_o
);

  // R1
  always_comb if (!rst_n) reset_low_chk: assert (rts_o == 1'b0);

  // R2
  disabled_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !rts_o);

  // R3
  auto_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !manual_mode && !invert && rx_count >= thresh) |=> rts_o);

  // R4
  auto_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !manual_mode && rx_count < thresh) |=> (rts_o == $past(invert)));

  // R5
  manual_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && manual_mode) |=> (rts_o == $past(manual_level)));

endmodule

bind rts_flow_ctrl rts_flow_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .manual_mode(manual_mode),
  .thresh(thresh), .invert(invert), .manual_level(manual_level),
  .rx_count(rx_count), .rts_o(rts_o)
);

// File: tb/sim_rts_flow_ctrl.sv
module sim_rts_flow_ctrl;
  localparam int CNT_W = 5;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, manual_mode = 1'b0, invert = 1'b0, manual_level = 1'b0;
  logic [CNT_W-1:0] thresh = '0, rx_count = '0;
  logic rts_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  rts_flow_ctrl #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .manual_mode(manual_mode),
    .thresh(thresh), .invert(invert), .manual_level(manual_level),
    .rx_count(rx_count), .rts_o(rts_o)
  );

  function automatic logic model(logic e, logic m, int t, logic inv, logic lvl, int c);
    if (!e) return 1'b0;
    if (m) return lvl;
    return (c >= t) ^ inv;
  endfunction

  task automatic check(string req, logic exp);
    checks++;
    if (rts_o !== exp) begin
      fails++;
      $display("FAIL %s: rts_o=%b expected=%b (en=%b mode=%b thr=%0d inv=%b lvl=%b cnt=%0d)",
               req, rts_o, exp, en, manual_mode, thresh, invert, manual_level, rx_count);
    end
  endtask

  task automatic apply(logic e, logic m, int t, logic inv, logic lvl, int c, string req);
    @(negedge clk);
    en = e; manual_mode = m; thresh = t[CNT_W-1:0]; invert = inv;
    manual_level = lvl; rx_count = c[CNT_W-1:0];
    @(posedge clk); #1;
    check(req, model(e, m, t, inv, lvl, c));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: cycles=%0d expected<=100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    logic prev;
    seed = $urandom(32'd2024);
    en = 1'b1; manual_mode = 1'b1; manual_level = 1'b1; invert = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1", 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // R2 disabled with everything else pushing high
    apply(0, 1, 0, 1, 1, 5, "R2");
    apply(0, 0, 0, 1, 1, MAXC, "R2");
    apply(0, 0, 0, 0, 0, MAXC, "R2");

    // R3 / R4 walk across the threshold
    for (int c = 4; c <= 10; c++) apply(1, 0, 7, 0, 0, c, "R3");
    for (int c = 10; c >= 4; c--) apply(1, 0, 7, 1, 0, c, "R4");

    // R5 invert ignored in manual mode; R6 count/thresh ignored
    apply(1, 1, 3, 0, 1, 0, "R5");
    apply(1, 1, 3, 1, 1, 0, "R5");
    apply(1, 1, 3, 1, 0, MAXC, "R5");
    apply(1, 1, 0, 0, 0, MAXC, "R6");
    apply(1, 1, MAXC, 0, 1, 0, "R6");

    // R8 boundary thresholds
    apply(1, 0, 0, 0, 0, 0, "R8");
    apply(1, 0, MAXC, 0, 0, MAXC - 1, "R8");
    apply(1, 0, MAXC, 0, 0, MAXC, "R8");

    // R7 latency: output holds until the next edge
    apply(1, 0, 6, 0, 0, 5, "R7");
    prev = rts_o;
    @(negedge clk);
    rx_count = 6;
    #1 check("R7", prev);
    @(posedge clk); #1 check("R7", 1'b1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic e, m, inv, lvl;
      int t, c;
      string tag;
      e = ($urandom % 8) != 0;
      m = $urandom % 2;
      inv = $urandom % 2;
      lvl = $urandom % 2;
      t = $urandom % (MAXC + 1);
      c = $urandom % (MAXC + 1);
      if (!e) tag = "R2";
      else if (m) tag = "R5";
      else if (inv) tag = "R4";
      else tag = "R3";
      apply(e, m, t, inv, lvl, c, tag);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule